// File: doc/BRIEF.md
# AXI Read Burst Throttle

This block sits on the read path between an AXI read master that may not take data every cycle and a downstream slave or crossbar that must never be stalled on its read data channel. It owns a local buffer for read data beats on the master side. A read address request is passed downstream only once the buffer can hold every beat of the burst it asks for, counting both the beats already held and the beats of earlier bursts still on their way. Downstream read data is therefore always accepted the moment it arrives, and the master empties the buffer at whatever rate suits it.

Address requests pass through without a register stage: the gate acts in the same cycle the request is presented. Read data, ID, response and last flag are stored together and leave the buffer in arrival order. Only one clock is used, and bursts come back from downstream in the order they were requested. The buffer depth is never below the largest burst length, so any legal burst can be admitted once the buffer drains.

Top module: `rd_burst_gate`

## Requirements
- R1: After synchronous reset the buffer is empty and no beats are reserved: upstream read valid is low, downstream read ready is low and no address request is forwarded while upstream address valid is low.
- R2: When the free space (buffer depth minus held beats minus beats still expected) is at least ARLEN+1, the upstream request appears downstream in the same cycle with address, ID and length unchanged, and upstream address ready follows downstream address ready.
- R3: When the free space is below ARLEN+1, downstream address valid and upstream address ready are both low; beats reserved but not yet received count as used space.
- R4: Downstream read ready is high in any cycle where downstream address valid is high, and low when no beats are outstanding and no request is being forwarded.
- R5: Once downstream read ready is high it stays high through every cycle until the last expected beat has transferred.
- R6: Every beat received downstream reaches the upstream master in arrival order with data, ID, response and last flag intact.
- R7: While upstream read valid is high and upstream read ready is low, valid stays high and data, ID, response and last stay stable.
- R8: A downstream beat that belongs to an admitted burst is never back-pressured: downstream read valid implies downstream read ready.
- R9: Each beat popped by the upstream master frees exactly one slot: with a full buffer, a single-beat request (ARLEN=0) is forwarded in the cycle after one pop and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_ar_valid | input | 1 | Upstream address request valid |
| up_ar_ready | output | 1 | Upstream address request accepted |
| up_ar_addr | input | ADDR_W | Upstream request address |
| up_ar_id | input | ID_W | Upstream request ID |
| up_ar_len | input | 8 | Upstream burst length minus one |
| up_r_valid | output | 1 | Buffered beat available to master |
| up_r_ready | input | 1 | Master takes the buffered beat |
| up_r_data | output | DATA_W | Beat data to master |
| up_r_id | output | ID_W | Beat ID to master |
| up_r_resp | output | 2 | Beat response to master |
| up_r_last | output | 1 | Final beat of burst to master |
| dn_ar_valid | output | 1 | Forwarded address request valid |
| dn_ar_ready | input | 1 | Downstream accepts the request |
| dn_ar_addr | output | ADDR_W | Forwarded address |
| dn_ar_id | output | ID_W | Forwarded ID |
| dn_ar_len | output | 8 | Forwarded burst length minus one |
| dn_r_valid | input | 1 | Downstream beat valid |
| dn_r_ready | output | 1 | Block accepts downstream beat |
| dn_r_data | input | DATA_W | Downstream beat data |
| dn_r_id | input | ID_W | Downstream beat ID |
| dn_r_resp | input | 2 | Downstream beat response |
| dn_r_last | input | 1 | Final beat of burst from downstream |

## Verification
A reservation count that runs high shows at the ports as a request held back although the buffer visibly has room, seen in the very cycle the request is presented; one that runs low shows as a request admitted into a full buffer, which corrupts or loses beats a few cycles later when the master drains and the delivered data no longer matches what the slave sent. A wrong expected-beat count shows as downstream read ready dropping before the last beat or staying high after it, visible on the cycle after the final transfer. Buffer pointer errors appear as reordered, repeated or changed beats at the upstream read port, detected on the first pop that reaches the damaged slot.

// File: rtl/rd_gate_pkg.sv
package rd_gate_pkg;

    // Burst length field width and response width are fixed by the protocol.
    localparam int LEN_W  = 8;
    localparam int RESP_W = 2;

    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [RESP_W-1:0] resp_t;

    // Number of beats a burst occupies, one more than the length field.
    function automatic logic [LEN_W:0] beats_of(input len_t len);
        return {1'b0, len} + 1'b1;
    endfunction

    // Width needed to hold any value from zero up to n.
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rd_gate_admit.sv
module rd_gate_admit
    import rd_gate_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  len_t req_len,
    input  logic fwd_ready,
    input  logic beat_in,
    input  logic beat_out,
    output logic fits,
    output logic pending_nz
);
    localparam int CNT_W = cnt_width(DEPTH);
    localparam int CMP_W = ((CNT_W > LEN_W + 1) ? CNT_W : LEN_W + 1) + 1;

    // Slots held in the buffer plus slots promised to bursts in flight.
    logic [CNT_W-1:0] resv_q;
    // Beats still expected from downstream.
    logic [CNT_W-1:0] pend_q;

    logic [CMP_W-1:0] need_w;
    logic [CMP_W-1:0] free_w;
    logic             take;
    logic [CNT_W-1:0] add_v;

    always_comb begin
        need_w = CMP_W'(beats_of(req_len));
        free_w = CMP_W'(DEPTH) - CMP_W'(resv_q);
        fits   = (need_w <= free_w);
        take   = req_valid & fits & fwd_ready;
        add_v  = take ? CNT_W'(need_w) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resv_q <= '0;
            pend_q <= '0;
        end else begin
            resv_q <= resv_q + add_v - CNT_W'(beat_out);
            pend_q <= pend_q + add_v - CNT_W'(beat_in);
        end
    end

    assign pending_nz = (pend_q != '0);

endmodule

// File: rtl/rd_gate_fifo.sv
module rd_gate_fifo
    import rd_gate_pkg::*;
#(
    parameter int  DEPTH = 16,
    parameter type T     = logic
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  T     wr_item,
    input  logic pop,
    output T     rd_item,
    output logic not_empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = cnt_width(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    T                 mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fill;
    logic             do_push;
    logic             do_pop;

    assign not_empty = (fill != '0);
    assign do_pop    = pop & not_empty;
    assign do_push   = push & (fill != CNT_W'(DEPTH));
    assign rd_item   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wr_item;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            fill <= fill + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

endmodule

// File: rtl/rd_burst_gate.sv
module rd_burst_gate
    import rd_gate_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ID_W      = 4,
    parameter int ADDR_W    = 32,
    parameter int MAX_BEATS = 16,
    parameter int BUF_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_ar_valid,
    output logic              up_ar_ready,
    input  logic [ADDR_W-1:0] up_ar_addr,
    input  logic [ID_W-1:0]   up_ar_id,
    input  logic [LEN_W-1:0]  up_ar_len,
    output logic              up_r_valid,
    input  logic              up_r_ready,
    output logic [DATA_W-1:0] up_r_data,
    output logic [ID_W-1:0]   up_r_id,
    output logic [RESP_W-1:0] up_r_resp,
    output logic              up_r_last,
    output logic              dn_ar_valid,
    input  logic              dn_ar_ready,
    output logic [ADDR_W-1:0] dn_ar_addr,
    output logic [ID_W-1:0]   dn_ar_id,
    output logic [LEN_W-1:0]  dn_ar_len,
    input  logic              dn_r_valid,
    output logic              dn_r_ready,
    input  logic [DATA_W-1:0] dn_r_data,
    input  logic [ID_W-1:0]   dn_r_id,
    input  logic [RESP_W-1:0] dn_r_resp,
    input  logic              dn_r_last
);
    // The buffer never holds fewer slots than the largest burst.
    localparam int DEPTH = (BUF_DEPTH > MAX_BEATS) ? BUF_DEPTH : MAX_BEATS;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ID_W-1:0]   id;
        resp_t             resp;
        logic              last;
    } beat_t;

    logic  fits;
    logic  pending_nz;
    logic  beat_in;
    logic  beat_out;
    beat_t in_beat;
    beat_t out_beat;

    rd_gate_admit #(
        .DEPTH(DEPTH)
    ) admit_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (up_ar_valid),
        .req_len   (up_ar_len),
        .fwd_ready (dn_ar_ready),
        .beat_in   (beat_in),
        .beat_out  (beat_out),
        .fits      (fits),
        .pending_nz(pending_nz)
    );

    // Address path: gated pass-through. Free space only grows while a
    // request waits, so a forwarded valid never falls before its handshake.
    assign dn_ar_valid = up_ar_valid & fits;
    assign up_ar_ready = dn_ar_ready & fits;
    assign dn_ar_addr  = up_ar_addr;
    assign dn_ar_id    = up_ar_id;
    assign dn_ar_len   = up_ar_len;

    // Ready is raised with the request and held while beats are owed.
    assign dn_r_ready = pending_nz | dn_ar_valid;
    assign beat_in    = dn_r_valid & dn_r_ready;

    assign in_beat = '{data: dn_r_data, id: dn_r_id, resp: dn_r_resp, last: dn_r_last};

    rd_gate_fifo #(
        .DEPTH(DEPTH),
        .T    (beat_t)
    ) buf_i (
        .clk      (clk),
        .rst      (rst),
        .push     (beat_in),
        .wr_item  (in_beat),
        .pop      (up_r_ready),
        .rd_item  (out_beat),
        .not_empty(up_r_valid)
    );

    assign beat_out  = up_r_valid & up_r_ready;
    assign up_r_data = out_beat.data;
    assign up_r_id   = out_beat.id;
    assign up_r_resp = out_beat.resp;
    assign up_r_last = out_beat.last;

endmodule

// File: rtl/rd_burst_gate_chk.sv
module rd_burst_gate_chk
    import rd_gate_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              up_ar_valid,
    input logic              up_r_valid,
    input logic              up_r_ready,
    input logic [DATA_W-1:0] up_r_data,
    input logic [ID_W-1:0]   up_r_id,
    input logic [RESP_W-1:0] up_r_resp,
    input logic              up_r_last,
    input logic              dn_ar_valid,
    input logic              dn_ar_ready,
    input logic [ADDR_W-1:0] dn_ar_addr,
    input logic [ID_W-1:0]   dn_ar_id,
    input logic [LEN_W-1:0]  dn_ar_len,
    input logic              dn_r_valid,
    input logic              dn_r_ready,
    input logic              dn_r_last
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !up_r_valid);

    // R2
    ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dn_ar_valid && !dn_ar_ready |=> dn_ar_valid && $stable(dn_ar_addr)
            && $stable(dn_ar_id) && $stable(dn_ar_len));

    // R3
    ar_requested_chk: assert property (@(posedge clk) disable iff (rst)
        dn_ar_valid |-> up_ar_valid);

    // R4
    ar_rready_chk: assert property (@(posedge clk) disable iff (rst)
        dn_ar_valid |-> dn_r_ready);

    // R5
    rready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dn_r_valid && dn_r_ready && !dn_r_last |=> dn_r_ready);

    // R7
    up_hold_chk: assert property (@(posedge clk) disable iff (rst)
        up_r_valid && !up_r_ready |=> up_r_valid && $stable(up_r_data)
            && $stable(up_r_id) && $stable(up_r_resp) && $stable(up_r_last));

    // R8
    no_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
        dn_r_valid |-> dn_r_ready);

endmodule

bind rd_burst_gate rd_burst_gate_chk #(
    .DATA_W(DATA_W),
    .ID_W  (ID_W),
    .ADDR_W(ADDR_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .up_ar_valid(up_ar_valid),
    .up_r_valid (up_r_valid),
    .up_r_ready (up_r_ready),
    .up_r_data  (up_r_data),
    .up_r_id    (up_r_id),
    .up_r_resp  (up_r_resp),
    .up_r_last  (up_r_last),
    .dn_ar_valid(dn_ar_valid),
    .dn_ar_ready(dn_ar_ready),
    .dn_ar_addr (dn_ar_addr),
    .dn_ar_id   (dn_ar_id),
    .dn_ar_len  (dn_ar_len),
    .dn_r_valid (dn_r_valid),
    .dn_r_ready (dn_r_ready),
    .dn_r_last  (dn_r_last)
);

// File: tb/rd_burst_gate_tb_top.sv
module rd_burst_gate_tb_top;
    import rd_gate_pkg::*;

    localparam int DATA_W = 32;
    localparam int ID_W   = 4;
    localparam int ADDR_W = 32;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              up_ar_valid = 1'b0;
    logic              up_ar_ready;
    logic [ADDR_W-1:0] up_ar_addr = '0;
    logic [ID_W-1:0]   up_ar_id = '0;
    logic [LEN_W-1:0]  up_ar_len = '0;
    logic              up_r_valid;
    logic              up_r_ready = 1'b0;
    logic [DATA_W-1:0] up_r_data;
    logic [ID_W-1:0]   up_r_id;
    logic [RESP_W-1:0] up_r_resp;
    logic              up_r_last;
    logic              dn_ar_valid;
    logic              dn_ar_ready = 1'b1;
    logic [ADDR_W-1:0] dn_ar_addr;
    logic [ID_W-1:0]   dn_ar_id;
    logic [LEN_W-1:0]  dn_ar_len;
    logic              dn_r_valid = 1'b0;
    logic              dn_r_ready;
    logic [DATA_W-1:0] dn_r_data = '0;
    logic [ID_W-1:0]   dn_r_id = '0;
    logic [RESP_W-1:0] dn_r_resp = '0;
    logic              dn_r_last = 1'b0;

    always #4 clk = ~clk;

    rd_burst_gate #(
        .DATA_W   (DATA_W),
        .ID_W     (ID_W),
        .ADDR_W   (ADDR_W),
        .MAX_BEATS(DEPTH),
        .BUF_DEPTH(DEPTH)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .up_ar_valid(up_ar_valid),
        .up_ar_ready(up_ar_ready),
        .up_ar_addr (up_ar_addr),
        .up_ar_id   (up_ar_id),
        .up_ar_len  (up_ar_len),
        .up_r_valid (up_r_valid),
        .up_r_ready (up_r_ready),
        .up_r_data  (up_r_data),
        .up_r_id    (up_r_id),
        .up_r_resp  (up_r_resp),
        .up_r_last  (up_r_last),
        .dn_ar_valid(dn_ar_valid),
        .dn_ar_ready(dn_ar_ready),
        .dn_ar_addr (dn_ar_addr),
        .dn_ar_id   (dn_ar_id),
        .dn_ar_len  (dn_ar_len),
        .dn_r_valid (dn_r_valid),
        .dn_r_ready (dn_r_ready),
        .dn_r_data  (dn_r_data),
        .dn_r_id    (dn_r_id),
        .dn_r_resp  (dn_r_resp),
        .dn_r_last  (dn_r_last)
    );

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ID_W-1:0]   id;
        resp_t             resp;
        logic              last;
    } exp_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
        len_t              len;
    } req_t;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t exp_q[$];
    req_t slv_q[$];
    logic slave_en = 1'b1;
    logic s_fire   = 1'b0;
    int   slv_beat = 0;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Downstream slave model: returns bursts in request order and records
    // the beats the master must later see.
    initial begin
        forever begin
            @(negedge clk);
            if (s_fire) begin
                slv_beat++;
                if (slv_beat > int'(slv_q[0].len)) begin
                    void'(slv_q.pop_front());
                    slv_beat = 0;
                end
            end
            if (slv_q.size() > 0 && (slave_en || (dn_r_valid && !s_fire))) begin
                dn_r_valid = 1'b1;
                dn_r_data  = DATA_W'(slv_q[0].addr + ADDR_W'(slv_beat));
                dn_r_id    = slv_q[0].id;
                dn_r_resp  = RESP_W'(slv_beat);
                dn_r_last  = (slv_beat == int'(slv_q[0].len));
            end else begin
                dn_r_valid = 1'b0;
            end
            #3;
            s_fire = dn_r_valid & dn_r_ready;
            if (dn_r_valid) begin
                chk(dn_r_ready, "R8 downstream beat back-pressured", 64'(dn_r_ready), 64'd1);
            end
            if (!rst && dn_ar_valid && dn_ar_ready) begin
                slv_q.push_back('{addr: dn_ar_addr, id: dn_ar_id, len: dn_ar_len});
                for (int i = 0; i <= int'(dn_ar_len); i++) begin
                    exp_q.push_back('{data: DATA_W'(dn_ar_addr + ADDR_W'(i)), id: dn_ar_id,
                                      resp: RESP_W'(i), last: (i == int'(dn_ar_len))});
                end
            end
        end
    end

    // Upstream monitor: compares popped beats with the scoreboard and checks
    // that a waiting beat holds still.
    initial begin
        logic hold_prev = 1'b0;
        exp_t seen_prev = '0;
        forever begin
            @(negedge clk);
            #3;
            if (!rst) begin
                if (hold_prev) begin
                    chk(up_r_valid && {up_r_data, up_r_id, up_r_resp, up_r_last} == seen_prev,
                        "R7 waiting beat changed",
                        64'({up_r_data, up_r_id, up_r_resp, up_r_last}), 64'(seen_prev));
                end
                if (up_r_valid && up_r_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R6 unexpected beat", 64'(up_r_data), 64'd0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk({up_r_data, up_r_id, up_r_resp, up_r_last} == e,
                            "R6 beat content or order",
                            64'({up_r_data, up_r_id, up_r_resp, up_r_last}), 64'(e));
                    end
                end
                hold_prev = up_r_valid && !up_r_ready;
                seen_prev = {up_r_data, up_r_id, up_r_resp, up_r_last};
            end
        end
    end

    task automatic issue_ar(input logic [ADDR_W-1:0] a, input logic [ID_W-1:0] id,
                            input len_t len);
        int guard = 0;
        @(negedge clk);
        up_ar_valid = 1'b1;
        up_ar_addr  = a;
        up_ar_id    = id;
        up_ar_len   = len;
        forever begin
            #3;
            if (up_ar_ready || guard > 3000) break;
            guard++;
            @(negedge clk);
        end
        @(negedge clk);
        up_ar_valid = 1'b0;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #3;
            if (exp_q.size() == 0 && slv_q.size() == 0 && !up_r_valid) break;
        end
        chk(exp_q.size() == 0, "R6 beats left undelivered", 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL R6 watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #3;
        // R1 reset state
        chk(!up_r_valid, "R1 read valid after reset", 64'(up_r_valid), 64'd0);
        chk(!dn_r_ready, "R1 downstream ready after reset", 64'(dn_r_ready), 64'd0);
        chk(!dn_ar_valid, "R1 no forwarded request after reset", 64'(dn_ar_valid), 64'd0);

        // R2 simple pass-through of a four-beat burst
        up_r_ready = 1'b1;
        @(negedge clk);
        up_ar_valid = 1'b1;
        up_ar_addr  = 32'h1000;
        up_ar_id    = 4'h3;
        up_ar_len   = 8'd3;
        #3;
        chk(dn_ar_valid && up_ar_ready, "R2 request forwarded", 64'({dn_ar_valid, up_ar_ready}), 64'h3);
        chk({dn_ar_addr, dn_ar_id, dn_ar_len} == {32'h1000, 4'h3, 8'd3}, "R2 request payload",
            64'({dn_ar_addr, dn_ar_id, dn_ar_len}), 64'({32'h1000, 4'h3, 8'd3}));
        chk(dn_r_ready, "R4 ready with forwarded request", 64'(dn_r_ready), 64'd1);
        @(negedge clk);
        up_ar_valid = 1'b0;
        wait_drain();
        #1;
        chk(!dn_r_ready, "R4 ready low when idle", 64'(dn_r_ready), 64'd0);

        // R9 fill the buffer completely, then one pop admits one beat
        up_r_ready = 1'b0;
        issue_ar(32'h2000, 4'h5, 8'd15);
        repeat (25) @(negedge clk);
        up_ar_valid = 1'b1;
        up_ar_addr  = 32'h3000;
        up_ar_id    = 4'h6;
        up_ar_len   = 8'd0;
        for (int i = 0; i < 4; i++) begin
            #3;
            chk(!dn_ar_valid && !up_ar_ready, "R3 held with full buffer",
                64'({dn_ar_valid, up_ar_ready}), 64'd0);
            chk(!dn_r_ready, "R4 ready low with nothing owed", 64'(dn_r_ready), 64'd0);
            @(negedge clk);
        end
        up_r_ready = 1'b1;
        #3;
        chk(!dn_ar_valid, "R9 not admitted before the pop", 64'(dn_ar_valid), 64'd0);
        @(negedge clk);
        up_r_ready = 1'b0;
        #3;
        chk(dn_ar_valid && up_ar_ready, "R9 admitted after one pop",
            64'({dn_ar_valid, up_ar_ready}), 64'h3);
        @(negedge clk);
        up_ar_valid = 1'b0;
        up_r_ready  = 1'b1;
        wait_drain();

        // R3 reserved but unfilled slots count as used
        slave_en = 1'b0;
        repeat (2) @(negedge clk);
        issue_ar(32'h4000, 4'h1, 8'd7);
        issue_ar(32'h5000, 4'h2, 8'd7);
        @(negedge clk);
        up_ar_valid = 1'b1;
        up_ar_addr  = 32'h6000;
        up_ar_id    = 4'h9;
        up_ar_len   = 8'd0;
        for (int i = 0; i < 3; i++) begin
            #3;
            chk(!dn_ar_valid, "R3 held while beats are reserved", 64'(dn_ar_valid), 64'd0);
            chk(!up_r_valid, "R3 buffer still empty", 64'(up_r_valid), 64'd0);
            chk(dn_r_ready, "R5 ready held while beats owed", 64'(dn_r_ready), 64'd1);
            @(negedge clk);
        end
        slave_en = 1'b1;
        for (int i = 0; i < 200; i++) begin
            #3;
            if (up_ar_ready) break;
            @(negedge clk);
        end
        chk(up_ar_ready, "R3 admitted once space frees", 64'(up_ar_ready), 64'd1);
        @(negedge clk);
        up_ar_valid = 1'b0;
        wait_drain();

        // R6 R7 mixed burst lengths under a stalling master
        fork
            begin
                issue_ar(32'h7000, 4'h0, 8'd0);
                issue_ar(32'h7100, 4'h1, 8'd1);
                issue_ar(32'h7200, 4'h2, 8'd5);
                issue_ar(32'h7300, 4'h3, 8'd15);
                issue_ar(32'h7400, 4'h4, 8'd2);
                issue_ar(32'h7500, 4'h5, 8'd7);
            end
            begin
                for (int c = 0; c < 300; c++) begin
                    @(negedge clk);
                    up_r_ready = ((c % 3) != 0) && ((c % 7) != 2);
                end
                @(negedge clk);
                up_r_ready = 1'b1;
            end
        join
        wait_drain();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule